// File: doc/BRIEF.md
# In-band control frame extractor

This block watches a video frame as it streams in, pixel by pixel, and decides whether the frame is really a command frame in disguise. Three groups of lines sit at fixed positions in the frame. Each group starts with two header lines and carries thirty lines of payload after them. When the header lines of the first group hold the expected 24-bit pattern, the frame is taken as a control frame. Payload pixels of every group whose header checks out then leave the block as tagged register-write words. A display-suppress flag tells the rest of the video path to drop the frame.

The pixel source supplies a one-cycle `frame_start` strobe before each frame. Each pixel arrives with `pix_valid` and its line and pixel indices. Pixels come in raster order. The block keeps no frame buffer. Payload words come out one cycle after the pixel that carried them, and a group's header is fully known only by the time its first payload line arrives.

The controller has five states. `S_IDLE` is the state after reset. `S_HDR` checks the header lines of the current group. `S_PAY` emits payload words. `S_VIDEO` holds for the rest of a frame that failed its first header, and `S_SKIP` holds for the rest of a control frame after a failed later header or after the last group. The transitions are:
- START: any state goes to `S_HDR` for group 0 on `frame_start`.
- ACCEPT: `S_HDR` goes to `S_PAY` at the first pixel past the two header lines, when every header pixel matched.
- REJECT: `S_HDR` goes to `S_VIDEO` instead of ACCEPT when the group is group 0, and to `S_SKIP` when it is a later group.
- NEXT: `S_PAY` goes to `S_HDR` of the following group when a pixel of the next group's first header line arrives.
- END: `S_PAY` of the last group goes to `S_SKIP` when a pixel past its payload arrives.

Top module: `ctrl_frame_extractor`

## Requirements
- R1: After reset, `wr_valid` and `suppress` are 0.
- R2: A header pixel matches when bits [23:16] equal 8'hE8 and bits [15:10] equal the group's command code. Bits [9:0] are ignored. Every pixel of both header lines must match for the group to pass.
- R3: Group g uses header lines 32g and 32g+1. The command codes and output type tags are: group 0 config, code 6'b111111, `wr_type` 0; group 1 brightness, code 6'b101010, `wr_type` 1; group 2 current calibration, code 6'b010101, `wr_type` 2.
- R4: In a passing group, each pixel with index 0..63 on lines 32g+2 to 32g+31 produces exactly one write on the cycle after it arrives. The write carries `wr_data` equal to the pixel, `wr_type` of the group, `wr_drv` equal to the pixel index, and `wr_row` equal to the line minus 32g+2. Writes appear in arrival order.
- R5: Pixels with index 64 or above produce no write, although they are still checked on header lines.
- R6: If group 0's header fails, the frame is video: no writes are issued and `suppress` stays 0 until the next frame.
- R7: `suppress` stays 0 through the header lines. It rises on the cycle after the first payload pixel of a frame whose group 0 header passed, and it holds until the next `frame_start`.
- R8: If the header of group 1 or 2 fails, that group and every later group produce no writes. Writes already issued stand, and `suppress` stays 1.
- R9: Lines 96 and above produce no writes and do not change `suppress`.
- R10: `frame_start` takes priority over a pixel in the same cycle, and that pixel is dropped. On the next cycle `wr_valid` and `suppress` are 0, and checking restarts at group 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle strobe ahead of a new frame |
| pix_valid | input | 1 | A pixel is present this cycle |
| line_num | input | 10 | Line index of the pixel |
| pix_num | input | 10 | Pixel index within the line |
| pix_data | input | 24 | Pixel value |
| wr_valid | output | 1 | A control word is present |
| wr_data | output | 24 | Control word |
| wr_type | output | 2 | Command type tag (0 config, 1 brightness, 2 calibration) |
| wr_drv | output | 6 | Target driver index |
| wr_row | output | 5 | Payload row within the group |
| suppress | output | 1 | Current frame must not be displayed |

## Verification
The assertions assume that pixels of a frame arrive in raster order, with pixel 0 of each header line first and line indices never decreasing. They also assume that a `frame_start` is seen before the first pixel of any frame. The stimulus keeps to this: each frame is opened with a strobe on an idle cycle and then walks every line and pixel in order, with one blank cycle per line. The single deliberate departure is a strobe that coincides with a pixel, and the rules give `frame_start` priority in that case.

// File: rtl/cfx_pkg.sv
package cfx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HDR,
        S_PAY,
        S_VIDEO,
        S_SKIP
    } cfx_state_e;

    localparam int CMD_W = 6;
    localparam int TAG_W = 2;

    // command code expected in the header of each group
    function automatic logic [CMD_W-1:0] group_cmd(input logic [TAG_W-1:0] grp);
        logic [CMD_W-1:0] code;
        case (grp)
            2'd0:    code = 6'b111111;
            2'd1:    code = 6'b101010;
            2'd2:    code = 6'b010101;
            default: code = 6'b000000;
        endcase
        return code;
    endfunction

endpackage

// File: rtl/cfx_hdr_check.sv
module cfx_hdr_check
    import cfx_pkg::*;
#(
    parameter int          DATA_W = 24,
    parameter logic [7:0]  SYNC   = 8'hE8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              chk_en,
    input  logic              chk_first,
    input  logic [DATA_W-1:0] pix,
    input  logic [CMD_W-1:0]  cmd,
    output logic              hdr_ok
);
    localparam int CNT_W = DATA_W - 8 - CMD_W;

    logic [DATA_W-1:0] expect_w;
    logic [DATA_W-1:0] care_w;
    logic              match;

    always_comb begin
        expect_w = {SYNC, cmd, {CNT_W{1'b0}}};
        care_w   = {{(8 + CMD_W){1'b1}}, {CNT_W{1'b0}}};
        match    = ((pix ^ expect_w) & care_w) == '0;
    end

    // running AND over every header pixel of the group being checked
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_ok <= 1'b1;
        end else if (frame_start) begin
            hdr_ok <= 1'b1;
        end else if (chk_en) begin
            hdr_ok <= (chk_first | hdr_ok) & match;
        end
    end

    // R2: one bad pixel keeps the group failed until the next group restarts it
    a_r2_fail_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (!hdr_ok && chk_en && !chk_first && !frame_start) |=> !hdr_ok);

endmodule

// File: rtl/cfx_word_out.sv
module cfx_word_out #(
    parameter int DATA_W    = 24,
    parameter int DRV_W     = 6,
    parameter int ROW_W     = 5,
    parameter int PAY_LINES = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              emit,
    input  logic [DATA_W-1:0] in_data,
    input  logic [1:0]        in_type,
    input  logic [DRV_W-1:0]  in_drv,
    input  logic [ROW_W-1:0]  in_row,
    output logic              wr_valid,
    output logic [DATA_W-1:0] wr_data,
    output logic [1:0]        wr_type,
    output logic [DRV_W-1:0]  wr_drv,
    output logic [ROW_W-1:0]  wr_row
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_data  <= '0;
            wr_type  <= '0;
            wr_drv   <= '0;
            wr_row   <= '0;
        end else begin
            wr_valid <= emit;
            if (emit) begin
                wr_data <= in_data;
                wr_type <= in_type;
                wr_drv  <= in_drv;
                wr_row  <= in_row;
            end
        end
    end

    a_r4_row_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (int'(wr_row) < PAY_LINES));

    a_r3_type_code: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_type != 2'd3));

endmodule

// File: rtl/ctrl_frame_extractor.sv
module ctrl_frame_extractor
    import cfx_pkg::*;
#(
    parameter int         DATA_W     = 24,
    parameter int         LINE_W     = 10,
    parameter int         PIX_W      = 10,
    parameter int         STRIDE     = 32,
    parameter int         HDR_LINES  = 2,
    parameter int         NUM_GROUPS = 3,
    parameter int         DRIVERS    = 64,
    parameter logic [7:0] SYNC       = 8'hE8,
    localparam int        DRV_W      = $clog2(DRIVERS),
    localparam int        PAY_LINES  = STRIDE - HDR_LINES,
    localparam int        ROW_W      = $clog2(PAY_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              pix_valid,
    input  logic [LINE_W-1:0] line_num,
    input  logic [PIX_W-1:0]  pix_num,
    input  logic [DATA_W-1:0] pix_data,
    output logic              wr_valid,
    output logic [DATA_W-1:0] wr_data,
    output logic [1:0]        wr_type,
    output logic [DRV_W-1:0]  wr_drv,
    output logic [ROW_W-1:0]  wr_row,
    output logic              suppress
);
    typedef logic [LINE_W-1:0] line_t;

    cfx_state_e       state_q, state_nxt;
    logic [TAG_W-1:0] grp_q, grp_nxt;
    logic             qual_q, qual_set;
    logic             hdr_ok;
    line_t            base_q, base_n;
    logic             chk_en, chk_first, emit;
    logic [ROW_W-1:0] row_n;

    // ---------------- next-state logic ----------------
    always_comb begin
        base_q    = line_t'(grp_q) * line_t'(STRIDE);
        state_nxt = state_q;
        grp_nxt   = grp_q;
        qual_set  = 1'b0;
        if (frame_start) begin
            state_nxt = S_HDR;                               // START
            grp_nxt   = '0;
        end else if (pix_valid) begin
            unique case (state_q)
                S_IDLE, S_VIDEO, S_SKIP: begin
                end
                S_HDR: begin
                    if (line_num >= base_q + line_t'(HDR_LINES)) begin
                        if (hdr_ok) begin
                            state_nxt = S_PAY;               // ACCEPT
                            qual_set  = (grp_q == '0);
                        end else if (grp_q == '0) begin
                            state_nxt = S_VIDEO;             // REJECT, first group
                        end else begin
                            state_nxt = S_SKIP;              // REJECT, later group
                        end
                    end
                end
                S_PAY: begin
                    if (line_num >= base_q + line_t'(STRIDE)) begin
                        if (grp_q == TAG_W'(NUM_GROUPS - 1)) begin
                            state_nxt = S_SKIP;              // END
                        end else begin
                            state_nxt = S_HDR;               // NEXT
                            grp_nxt   = grp_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // ---------------- per-pixel decode against the next state ----------------
    always_comb begin
        base_n    = line_t'(grp_nxt) * line_t'(STRIDE);
        chk_en    = pix_valid && !frame_start && (state_nxt == S_HDR)
                    && (line_num >= base_n) && (line_num < base_n + line_t'(HDR_LINES));
        chk_first = (line_num == base_n) && (pix_num == '0);
        emit      = pix_valid && !frame_start && (state_nxt == S_PAY)
                    && (pix_num < PIX_W'(DRIVERS));
        row_n     = ROW_W'(line_num - base_n - line_t'(HDR_LINES));
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            grp_q   <= '0;
            qual_q  <= 1'b0;
        end else begin
            state_q <= state_nxt;
            grp_q   <= grp_nxt;
            if (frame_start) begin
                qual_q <= 1'b0;
            end else if (qual_set) begin
                qual_q <= 1'b1;
            end
        end
    end

    assign suppress = qual_q;

    cfx_hdr_check #(
        .DATA_W (DATA_W),
        .SYNC   (SYNC)
    ) u_hdr (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .chk_en      (chk_en),
        .chk_first   (chk_first),
        .pix         (pix_data),
        .cmd         (group_cmd(grp_nxt)),
        .hdr_ok      (hdr_ok)
    );

    // ---------------- output process ----------------
    cfx_word_out #(
        .DATA_W    (DATA_W),
        .DRV_W     (DRV_W),
        .ROW_W     (ROW_W),
        .PAY_LINES (PAY_LINES)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .emit     (emit),
        .in_data  (pix_data),
        .in_type  (grp_nxt),
        .in_drv   (pix_num[DRV_W-1:0]),
        .in_row   (row_n),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .wr_type  (wr_type),
        .wr_drv   (wr_drv),
        .wr_row   (wr_row)
    );

    // ---------------- assertions ----------------
    a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (!suppress && !wr_valid));

    a_r7_write_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> suppress);

    a_r6_video_shown: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_VIDEO) |-> !suppress);

    a_r8_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SKIP) |-> !wr_valid);

endmodule

// File: tb/ctrl_frame_extractor_test.sv
module ctrl_frame_extractor_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        pix_valid = 1'b0;
    logic [9:0]  line_num = '0;
    logic [9:0]  pix_num = '0;
    logic [23:0] pix_data = '0;
    logic        wr_valid;
    logic [23:0] wr_data;
    logic [1:0]  wr_type;
    logic [5:0]  wr_drv;
    logic [4:0]  wr_row;
    logic        suppress;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    int cnt [3];
    int mism = 0;
    int exp_g = 0, exp_r = 0, exp_d = 0;

    always #5 clk = ~clk;

    ctrl_frame_extractor uut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pix_valid(pix_valid),
        .line_num(line_num), .pix_num(pix_num), .pix_data(pix_data),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_type(wr_type),
        .wr_drv(wr_drv), .wr_row(wr_row), .suppress(suppress)
    );

    // stimulus table: failing group (3 = none), failing header line, failing pixel,
    // fault kind (0 sync byte, 1 wrong command), expected passing groups, expected suppress
    localparam int NV = 6;
    localparam int V_G [NV] = '{3, 0, 1, 2, 0, 1};
    localparam int V_L [NV] = '{0, 1, 0, 1, 0, 1};
    localparam int V_P [NV] = '{0, 65, 0, 63, 10, 64};
    localparam int V_K [NV] = '{0, 0, 1, 0, 1, 1};
    localparam int V_N [NV] = '{3, 0, 1, 2, 0, 1};
    localparam int V_S [NV] = '{1, 0, 1, 1, 0, 1};

    function automatic logic [5:0] code_of(input int g);
        case (g)
            0:       return 6'b111111;
            1:       return 6'b101010;
            default: return 6'b010101;
        endcase
    endfunction

    function automatic logic [23:0] payload(input int line, input int pix);
        return {4'hA, 10'(line), 10'(pix)};
    endfunction

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // write monitor: beats must follow group, row, driver order (R4)
    always @(negedge clk) begin
        if (rst_n && wr_valid) begin
            if (wr_type < 2'd3) cnt[wr_type]++;
            if (int'(wr_type) != exp_g || int'(wr_row) != exp_r || int'(wr_drv) != exp_d ||
                wr_data != payload(exp_g * 32 + 2 + exp_r, exp_d))
                mism++;
            exp_d++;
            if (exp_d == 64) begin exp_d = 0; exp_r++; end
            if (exp_r == 30) begin exp_r = 0; exp_g++; end
        end
    end

    task automatic send_frame(input int bad_g, input int bad_l, input int bad_p,
                              input int kind, input int nlines, input int exp_supp);
        for (int k = 0; k < 3; k++) cnt[k] = 0;
        mism = 0; exp_g = 0; exp_r = 0; exp_d = 0;
        @(negedge clk);
        frame_start = 1'b1;
        pix_valid   = 1'b0;
        @(negedge clk);
        frame_start = 1'b0;
        for (int ln = 0; ln < nlines; ln++) begin
            for (int p = 0; p < 66; p++) begin
                @(negedge clk);
                if (ln == 2 && p == 0) chk("R7 low through header lines", int'(suppress), 0);
                if (ln == 2 && p == 1) chk("R7 rise after first payload pixel", int'(suppress), exp_supp);
                pix_valid = 1'b1;
                line_num  = 10'(ln);
                pix_num   = 10'(p);
                if (ln < 96 && (ln % 32) < 2) begin
                    pix_data = {8'hE8, code_of(ln / 32), 10'(p * 7 + ln)};
                    if ((ln / 32) == bad_g && (ln % 32) == bad_l && p == bad_p) begin
                        if (kind == 0) pix_data = pix_data ^ 24'h010000;
                        else           pix_data = {8'hE8, code_of((ln / 32 + 1) % 3), 10'(p)};
                    end
                end else begin
                    pix_data = payload(ln, p);
                end
            end
            @(negedge clk);
            pix_valid = 1'b0;
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 wr_valid in reset", int'(wr_valid), 0);
        chk("R1 suppress in reset", int'(suppress), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 wr_valid after reset", int'(wr_valid), 0);
        chk("R1 suppress after reset", int'(suppress), 0);

        // table walk: R2 R3 R4 R5 R6 R8 R9
        for (int v = 0; v < NV; v++) begin
            send_frame(V_G[v], V_L[v], V_P[v], V_K[v], 100, V_S[v]);
            for (int k = 0; k < 3; k++)
                chk($sformatf("R4/R6/R8 vec%0d type%0d write count", v, k), cnt[k],
                    (k < V_N[v]) ? 1920 : 0);
            chk($sformatf("R4 vec%0d order and content mismatches", v), mism, 0);
            chk($sformatf("R7/R9 vec%0d suppress held at frame end", v), int'(suppress), V_S[v]);
        end

        // R10: restart mid-payload with a pixel in the same cycle
        send_frame(3, 0, 0, 0, 6, 1);
        chk("R7 suppress held mid frame", int'(suppress), 1);
        chk("R4 partial frame writes", cnt[0], 4 * 64);
        @(negedge clk);
        frame_start = 1'b1;
        pix_valid   = 1'b1;
        line_num    = 10'd6;
        pix_num     = 10'd0;
        pix_data    = payload(6, 0);
        @(negedge clk);
        frame_start = 1'b0;
        pix_valid   = 1'b0;
        chk("R10 wr_valid after restart", int'(wr_valid), 0);
        chk("R10 suppress after restart", int'(suppress), 0);

        // R10: checking restarts at group 0 and a full frame passes again
        send_frame(3, 0, 0, 0, 100, 1);
        chk("R10 recovered config writes", cnt[0], 1920);
        chk("R10 recovered calibration writes", cnt[2], 1920);
        chk("R10 recovered mismatches", mism, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule